// File: doc/BRIEF.md
# Cyclic ADC Redundant-Digit Corrector

This block is the digital back end of a 12-bit cyclic converter made of 1.5-bit stages. Two stage decisions are resolved in each clock period, because the two conversion phases share one amplifier. Each decision comes in as a pair of registered comparator bits: one compares against a threshold at a quarter of the reference above mid-scale, the other against a threshold a quarter below it. The block turns each pair into a signed ternary digit (+1, 0 or −1) and weights the digits by powers of two, most significant first. It sums them in a signed accumulator, so that overlapping redundant digits cancel and no bits are simply concatenated. A comparator offset of up to an eighth of full scale therefore does not spoil the code.

A start request received while the block is idle opens a conversion. The next six clock edges each take one pair of decisions. In the clock after the last pair, the block adds the mid-scale offset, clamps the sum into the 12-bit range and presents it with a one-cycle done strobe. The result then holds until the next conversion completes. A comparator pair that no legal threshold crossing can produce is counted as a zero digit and raises a flag for that conversion.

Top module: `cyclic_adc_corrector`

## Requirements
- R1: While reset is low at a clock edge, result, done, busy and illegal_seen are all 0 after that edge.
- R2: A start_req sampled high while busy is low makes busy high after that edge. The following six edges each sample one pair of decisions, and busy falls at the sixth.
- R3: Each decision is encoded as {hi, lo}: 2'b11 is digit +1, 2'b01 is digit 0, and 2'b00 is digit −1.
- R4: On index 0 of cmp_hi/cmp_lo in conversion cycle c (c = 0 for the first sampled edge) the digit has weight 2^(11−2c); on index 1 it has weight 2^(10−2c). The result is 2048 plus the weighted sum of the twelve digits.
- R5: A sum below 0 gives result 0, and a sum above 4095 gives result 4095.
- R6: The pair {hi, lo} = 2'b10 is counted as digit 0. If it occurs on either index during a conversion, illegal_seen is high from then until the edge that accepts the next start, which clears it.
- R7: done is high for exactly one cycle, the cycle right after the edge that samples the last pair. busy is low in that cycle.
- R8: result changes only at the edge that raises done, and keeps its value in every other cycle, including cycles with arbitrary comparator inputs and no start.
- R9: A start_req sampled while busy is high has no effect: the conversion keeps its length and its result, and no new conversion follows.
- R10: Redundant digit patterns that carry the same weighted value give the same result. For example, +1 followed by −1 at the next lower position equals 0 followed by +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | Request to begin a conversion |
| cmp_hi | input | 2 | Upper-threshold comparator bits; index 0 is the more significant decision |
| cmp_lo | input | 2 | Lower-threshold comparator bits; index 0 is the more significant decision |
| busy | output | 1 | High while decisions are being taken |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | 12 | Corrected, clamped conversion code |
| illegal_seen | output | 1 | An impossible comparator pair occurred in this conversion |

## Verification
The bench aims at the two clamp edges. A leading +1 with all other digits zero sums to exactly 4096, and a leading −1 sums to exactly 0; a design with one bit too few in its accumulator, or a sign error, wraps these into mid-range codes instead of saturating. It runs the pairs +1,−1 and 0,+1 and checks that they meet at the same code; an implementation that concatenated bits rather than adding signed digits would give two different codes. It places a start request on the final decision edge, where a design that tested readiness on the wrong cycle would launch a phantom conversion or stretch the current one. It also checks that the illegal flag is cleared by the next start rather than by reset alone.

// File: rtl/cadc_pkg.sv
// Package: shared types for the cyclic ADC corrector.
// Assumes a ternary digit fits in a two-bit two's-complement value.
package cadc_pkg;
    typedef logic signed [1:0] sdigit_t;

    localparam sdigit_t DIG_POS  = 2'sb01;
    localparam sdigit_t DIG_ZERO = 2'sb00;
    localparam sdigit_t DIG_NEG  = 2'sb11;
endpackage

// File: rtl/cadc_digit_decode.sv
// Module: maps one comparator pair {hi, lo} to a signed ternary digit.
// Assumes the pair is already registered. The pair hi=1, lo=0 cannot arise
// from two ordered thresholds, so it is reported and counted as zero.
module cadc_digit_decode
    import cadc_pkg::*;
(
    input  logic    hi,
    input  logic    lo,
    output sdigit_t digit,
    output logic    illegal
);
    // Purpose: combinational pair-to-digit lookup.
    always_comb begin
        illegal = 1'b0;
        case ({hi, lo})
            2'b11:   digit = DIG_POS;
            2'b01:   digit = DIG_ZERO;
            2'b00:   digit = DIG_NEG;
            default: begin
                digit   = DIG_ZERO;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cadc_sequencer.sv
// Module: conversion cycle sequencer.
// Assumes start_req is synchronous to clk. A start is taken only when idle.
// The sequencer then runs CYCLES sampling edges and raises done once.
module cadc_sequencer #(
    parameter int CYCLES = 6,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    output logic             busy,
    output logic             start_ok,
    output logic             last_step,
    output logic [CNT_W-1:0] cyc_idx,
    output logic             done
);
    // Purpose: decode the start acceptance and the final step.
    always_comb begin
        start_ok  = start_req && !busy;
        last_step = busy && (cyc_idx == CNT_W'(CYCLES - 1));
    end

    // Purpose: hold the busy state, the cycle index and the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cyc_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= last_step;
            if (start_ok) begin
                busy    <= 1'b1;
                cyc_idx <= '0;
            end else if (busy) begin
                if (last_step) begin
                    busy    <= 1'b0;
                    cyc_idx <= '0;
                end else begin
                    cyc_idx <= cyc_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cadc_accum.sv
// Module: signed weighted accumulation of redundant digits, with offset and clamp.
// Assumes digits arrive DEC per step, lowest index first, where the lowest
// index is the most significant. The digit at decision position i has weight 2^(RES_BITS-1-i).
module cadc_accum #(
    parameter int RES_BITS = 12,
    parameter int DEC      = 2,
    parameter int CNT_W    = 3,
    localparam int ACC_W   = RES_BITS + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step_en,
    input  logic                finish,
    input  logic [CNT_W-1:0]    cyc_idx,
    input  logic [2*DEC-1:0]    digits,
    input  logic [DEC-1:0]      ill_vec,
    output logic [RES_BITS-1:0] result,
    output logic                illegal_seen
);
    localparam logic signed [ACC_W-1:0] OFFSET = ACC_W'(2 ** (RES_BITS - 1));
    localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'(2 ** RES_BITS - 1);

    logic signed [ACC_W-1:0] acc, acc_next, step_sum, term, biased;
    logic [RES_BITS-1:0]     clamped;
    int                      sh;

    // Purpose: weight this step's digits and form the biased, clamped sum.
    always_comb begin
        step_sum = '0;
        term     = '0;
        sh       = 0;
        for (int j = 0; j < DEC; j++) begin
            sh       = RES_BITS - 1 - (DEC * int'(cyc_idx) + j);
            term     = {{(ACC_W-2){digits[2*j+1]}}, digits[2*j +: 2]};
            step_sum = step_sum + (term <<< sh);
        end
        acc_next = acc + step_sum;
        biased   = acc_next + OFFSET;
        if (biased < 0)
            clamped = '0;
        else if (biased > MAXV)
            clamped = MAXV[RES_BITS-1:0];
        else
            clamped = biased[RES_BITS-1:0];
    end

    // Purpose: update the accumulator, the illegal flag and the held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc          <= '0;
            result       <= '0;
            illegal_seen <= 1'b0;
        end else if (clear) begin
            acc          <= '0;
            illegal_seen <= 1'b0;
        end else if (step_en) begin
            acc          <= acc_next;
            illegal_seen <= illegal_seen | (|ill_vec);
            if (finish)
                result <= clamped;
        end
    end
endmodule

// File: rtl/cyclic_adc_corrector.sv
// Module: top of the redundant-digit correction logic for a cyclic ADC.
// Assumes comparator bits are registered and valid at each sampling edge.
// Index 0 of cmp_hi/cmp_lo carries the more significant decision of a period.
module cyclic_adc_corrector #(
    parameter int RES_BITS    = 12,
    parameter int DEC_PER_CYC = 2,
    localparam int CYCLES     = RES_BITS / DEC_PER_CYC,
    localparam int CNT_W      = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_req,
    input  logic [DEC_PER_CYC-1:0] cmp_hi,
    input  logic [DEC_PER_CYC-1:0] cmp_lo,
    output logic                   busy,
    output logic                   done,
    output logic [RES_BITS-1:0]    result,
    output logic                   illegal_seen
);
    logic                     start_ok, last_step;
    logic [CNT_W-1:0]         cyc_idx;
    logic [2*DEC_PER_CYC-1:0] digits;
    logic [DEC_PER_CYC-1:0]   ill_vec;

    for (genvar j = 0; j < DEC_PER_CYC; j++) begin : g_dec
        cadc_digit_decode u_dec (
            .hi      (cmp_hi[j]),
            .lo      (cmp_lo[j]),
            .digit   (digits[2*j +: 2]),
            .illegal (ill_vec[j])
        );
    end

    cadc_sequencer #(.CYCLES(CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .busy      (busy),
        .start_ok  (start_ok),
        .last_step (last_step),
        .cyc_idx   (cyc_idx),
        .done      (done)
    );

    cadc_accum #(.RES_BITS(RES_BITS), .DEC(DEC_PER_CYC), .CNT_W(CNT_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start_ok),
        .step_en      (busy),
        .finish       (last_step),
        .cyc_idx      (cyc_idx),
        .digits       (digits),
        .ill_vec      (ill_vec),
        .result       (result),
        .illegal_seen (illegal_seen)
    );
endmodule

// File: rtl/cadc_checker.sv
// Module: protocol checker for cyclic_adc_corrector, attached by bind.
// Assumes only the top-level ports are visible.
module cadc_checker #(
    parameter int RES_BITS    = 12,
    parameter int DEC_PER_CYC = 2,
    localparam int CYCLES     = RES_BITS / DEC_PER_CYC
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_req,
    input logic [DEC_PER_CYC-1:0] cmp_hi,
    input logic [DEC_PER_CYC-1:0] cmp_lo,
    input logic                   busy,
    input logic                   done,
    input logic [RES_BITS-1:0]    result,
    input logic                   illegal_seen
);
    int run_len;

    // Purpose: count consecutive busy cycles so the conversion length can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= 0;
        else if (busy)  run_len <= run_len + 1;
        else            run_len <= 0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && !illegal_seen && result == '0));

    a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && !busy |=> busy);

    a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < CYCLES);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(busy) |-> done);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !done |-> $stable(result));

    a_r6_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (|(cmp_hi & ~cmp_lo)) |=> illegal_seen);
endmodule

bind cyclic_adc_corrector cadc_checker #(
    .RES_BITS    (RES_BITS),
    .DEC_PER_CYC (DEC_PER_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .cmp_hi       (cmp_hi),
    .cmp_lo       (cmp_lo),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .illegal_seen (illegal_seen)
);

// File: tb/test_cyclic_adc_corrector.sv
module test_cyclic_adc_corrector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic [1:0] cmp_hi = 2'b00;
    logic [1:0] cmp_lo = 2'b00;
    logic       busy, done, illegal_seen;
    logic [11:0] result;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cyclic_adc_corrector i_cyclic_adc_corrector (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .cmp_hi       (cmp_hi),
        .cmp_lo       (cmp_lo),
        .busy         (busy),
        .done         (done),
        .result       (result),
        .illegal_seen (illegal_seen)
    );

    // Twelve 2-bit {hi,lo} decisions (decision 0 in [23:22]) | expected result | expected illegal
    localparam int NV = 15;
    localparam logic [36:0] VECS [NV] = '{
        {24'h555555, 12'h800, 1'b0},  // R3 all zero digits
        {24'hFFFFFF, 12'hFFF, 1'b0},  // R5 all +1, clamp high
        {24'h000000, 12'h000, 1'b0},  // R5 all -1, clamp low
        {24'hD55555, 12'hFFF, 1'b0},  // R5 sum exactly 4096
        {24'h155555, 12'h000, 1'b0},  // R5 sum exactly 0
        {24'h755555, 12'hC00, 1'b0},  // R4 second decision of cycle 0
        {24'h555557, 12'h801, 1'b0},  // R4 least significant +1
        {24'h555554, 12'h7FF, 1'b0},  // R4 least significant -1
        {24'h715555, 12'hA00, 1'b0},  // R10 +1,-1 form
        {24'h5D5555, 12'hA00, 1'b0},  // R10 0,+1 form
        {24'h655555, 12'h800, 1'b1},  // R6 illegal pair on index 1
        {24'hB55555, 12'hC00, 1'b1},  // R6 illegal pair on index 0
        {24'hCCCCCC, 12'hD55, 1'b0},  // R4 alternating digits
        {24'h3FFFFF, 12'h7FF, 1'b0},  // R4 -1 then all +1
        {24'hC00000, 12'h801, 1'b0}   // R4 +1 then all -1
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_pair(input logic [23:0] codes, input int c);
        cmp_hi[0] = codes[23-4*c];
        cmp_lo[0] = codes[22-4*c];
        cmp_hi[1] = codes[21-4*c];
        cmp_lo[1] = codes[20-4*c];
    endtask

    // One full conversion; noisy_start holds start high from cycle 2 through the last sampling edge.
    task automatic convert(input logic [23:0] codes, input logic [11:0] exp_res,
                           input logic exp_ill, input bit noisy_start);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(illegal_seen == 1'b0, "R6 flag cleared by start", int'(illegal_seen), 0);
        drive_pair(codes, 0);
        for (int c = 1; c < 6; c++) begin
            @(negedge clk);
            check(done == 1'b0, "R7 no early done", int'(done), 0);
            drive_pair(codes, c);
            if (noisy_start && c >= 2) start_req = 1'b1;
        end
        @(negedge clk) start_req = 1'b0;
        check(done == 1'b1, "R7 done after last pair", int'(done), 1);
        check(busy == 1'b0, "R2 busy falls at sixth edge", int'(busy), 0);
        check(result == exp_res, "R4 result", int'(result), int'(exp_res));
        check(illegal_seen == exp_ill, "R6 illegal flag", int'(illegal_seen), int'(exp_ill));
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", int'(done), 0);
        check(busy == 1'b0, "R9 no restart from late start", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result == 12'd0 && !done && !busy && !illegal_seen, "R1 reset state",
              int'(result), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            convert(VECS[v][36:13], VECS[v][12:1], VECS[v][0], 1'b0);

        // R9: start held high during a conversion
        convert(24'h755555, 12'hC00, 1'b0, 1'b1);

        // R8: result holds without start, under changing comparator inputs
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            cmp_hi = 2'(k);
            cmp_lo = 2'(k + 1);
            check(result == 12'hC00, "R8 result held", int'(result), 12'hC00);
            check(busy == 1'b0 && done == 1'b0, "R8 stays idle", int'(busy), 0);
        end

        // R6: illegal conversion, then a clean one clears the flag
        convert(24'h655555, 12'h800, 1'b1, 1'b0);
        convert(24'h555555, 12'h800, 1'b0, 1'b0);

        // R1: reset in mid-conversion
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        cmp_hi = 2'b10;
        cmp_lo = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(result == 12'd0, "R1 reset clears result", int'(result), 0);
        check(!busy && !done && !illegal_seen, "R1 reset clears state", int'(busy), 0);
        rst_n = 1'b1;
        convert(24'hCCCCCC, 12'hD55, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule